// File: doc/BRIEF.md
# Peripheral Clock Prescaler and Gating

This block turns the system clock into single-cycle clock-enable strobes for the peripherals of a chip. Two programmable prescalers set the rates. One serves a fast peripheral domain and the other a slow one. A small fixed divider chain makes a strobe for the external-bus timing logic and a strobe for the external clock output. Each peripheral strobe is masked by its own enable bit. Clearing the bit silences that peripheral, which saves power. The PWM time-base strobes also pass through a shared release bit. While that bit is clear, every PWM channel stays stopped. When the bit is set, all enabled channels start on the same cycle.

Software programs the block through a simple write port. The port carries a write strobe, a 3-bit register address and a data word. The block has no read path. Prescaler writes never cut a divider period short. A new ratio takes over only when the running count reaches its terminal value.

Top module: `pclk_gen`

## Requirements
- R1: After reset, the fast prescaler runs at 1/2 and the slow prescaler at 1/4. The bus timing strobe runs at 1/2 and the clock-out strobe at 1/4. Every peripheral enable, every PWM enable and the release bit are 0, so `hs_stb`, `ls_stb` and `pwm_stb` are all zero.
- R2: A value N written to address 0, bits [2:0], sets the fast strobe period to 2*N system cycles. N = 0 gives a period of 1 cycle.
- R3: A value N written to address 1, bits [2:0], sets the slow strobe period in the same way: 2*N cycles, or 1 cycle for N = 0.
- R4: A prescale write takes effect at the running divider's next terminal count. The period in progress completes at the old length, and no period is ever shorter than either the old ratio or the new one.
- R5: Address 2, bit 0 selects the bus timing strobe rate: every second system cycle when the bit is 1, every cycle when it is 0.
- R6: Address 2, bit 1 set to 1 makes the clock-out strobe fire on every second bus timing strobe; set to 0, it fires on every one. Address 2, bit 2 set to 1 silences the clock-out strobe.
- R7: Address 3, bit i gates `hs_stb[i]` and address 4, bit i gates `ls_stb[i]`. A strobe fires only while its bit is 1.
- R8: Address 5, bit i enables PWM channel i, and address 6, bit 0 is the release bit. While the release bit is 0, `pwm_stb` stays zero. Once it is set, every enabled channel strobes on the fast-domain tick, and all of them give their first strobe on the same cycle.
- R9: A write to address 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| hs_stb | output | NUM_HS | Fast-domain peripheral enable strobes |
| ls_stb | output | NUM_LS | Slow-domain peripheral enable strobes |
| pwm_stb | output | NUM_PWM | PWM time-base enable strobes |
| bus_stb | output | 1 | External-bus timing strobe |
| xout_stb | output | 1 | External clock-out strobe |

## Verification
The bound checker watches several behaviours on every cycle. It measures the spacing between ticks against the ratio it tracks from the write port, which covers deferred loading and the absence of short periods. It also checks that no strobe escapes its enable bit, that the PWM channels are held and released in alignment, and that the clock-out strobe stays under the bus strobe and the clock-off bit. Only the bench scenarios can show some of the other behaviours. These include the exact rates over a whole window for each random or directed setting, the old period finishing at its full length after a write, and unmapped writes leaving every rate unchanged.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_HSPRE = 3'd0;
   localparam logic [ADDR_W-1:0] A_LSPRE = 3'd1;
   localparam logic [ADDR_W-1:0] A_BUS   = 3'd2;
   localparam logic [ADDR_W-1:0] A_HSEN  = 3'd3;
   localparam logic [ADDR_W-1:0] A_LSEN  = 3'd4;
   localparam logic [ADDR_W-1:0] A_PWMEN = 3'd5;
   localparam logic [ADDR_W-1:0] A_SYNC  = 3'd6;

   typedef struct packed {
      logic clk_off;   // bit 2
      logic out_half;  // bit 1
      logic bus_half;  // bit 0
   } bus_cfg_t;

   localparam bus_cfg_t BUS_CFG_RST = '{clk_off: 1'b0, out_half: 1'b1, bus_half: 1'b1};

   function automatic int unsigned pre_ratio(input int unsigned n);
      return (n == 0) ? 1 : 2 * n;
   endfunction
endpackage

// File: rtl/pclk_prescaler.sv
module pclk_prescaler #(
   parameter int PRE_W   = 3,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PRE_W-1:0] din,
   output logic             tick
);
   localparam int CNT_W = PRE_W + 1;

   generate
      if (PRE_W < 1 || RST_VAL < 0 || RST_VAL >= (1 << PRE_W)) begin : g_bad_cfg
         $error("pclk_prescaler: reset value does not fit the prescale width");
      end
   endgenerate

   logic [PRE_W-1:0] pend_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [CNT_W-1:0] reload_of(input logic [PRE_W-1:0] n);
      return (n == '0) ? '0 : ({n, 1'b0} - CNT_W'(1));
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= PRE_W'(RST_VAL);
         cnt_q  <= '0;
      end else begin
         if (load) pend_q <= din;
         if (cnt_q == '0) cnt_q <= reload_of(pend_q);
         else             cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign tick = (cnt_q == '0);
endmodule

// File: rtl/pclk_busclk.sv
module pclk_busclk
   import pclk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  bus_cfg_t cfg,
   output logic     bus_tick,
   output logic     out_tick
);
   logic ph_bus_q;
   logic ph_out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_bus_q <= 1'b0;
         ph_out_q <= 1'b0;
      end else begin
         ph_bus_q <= ~ph_bus_q;
         if (bus_tick) ph_out_q <= ~ph_out_q;
      end
   end

   assign bus_tick = cfg.bus_half ? ph_bus_q : 1'b1;
   assign out_tick = bus_tick & ~cfg.clk_off & (cfg.out_half ? ph_out_q : 1'b1);
endmodule

// File: rtl/pclk_gate.sv
module pclk_gate #(
   parameter int N        = 4,
   parameter bit USE_HOLD = 0
) (
   input  logic         tick,
   input  logic [N-1:0] en,
   input  logic         release_i,
   output logic [N-1:0] stb
);
   generate
      if (N < 1) begin : g_bad_n
         $error("pclk_gate: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (USE_HOLD) begin : g_held
            assign stb[i] = tick & en[i] & release_i;
         end else begin : g_free
            assign stb[i] = tick & en[i];
         end
      end
      if (!USE_HOLD) begin : g_unused
         logic unused_rel;
         assign unused_rel = release_i;
      end
   endgenerate
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
   import pclk_pkg::*;
#(
   parameter int PRE_W       = 3,
   parameter int DATA_W      = 4,
   parameter int NUM_HS      = 4,
   parameter int NUM_LS      = 4,
   parameter int NUM_PWM     = 4,
   parameter int HS_RST      = 1,
   parameter int LS_RST      = 2,
   parameter bit PWM_FROM_HS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NUM_HS-1:0] hs_stb,
   output logic [NUM_LS-1:0] ls_stb,
   output logic [NUM_PWM-1:0] pwm_stb,
   output logic              bus_stb,
   output logic              xout_stb
);
   localparam int MAX_EN = (NUM_HS > NUM_LS) ? ((NUM_HS > NUM_PWM) ? NUM_HS : NUM_PWM)
                                             : ((NUM_LS > NUM_PWM) ? NUM_LS : NUM_PWM);
   localparam int NEED_W = (MAX_EN > PRE_W) ? ((MAX_EN > 3) ? MAX_EN : 3)
                                            : ((PRE_W > 3) ? PRE_W : 3);

   generate
      if (DATA_W < NEED_W) begin : g_bad_dw
         $error("pclk_gen: DATA_W too narrow for the widest register");
      end
   endgenerate

   logic              hs_load, ls_load;
   logic              hs_tick, ls_tick, pwm_tick;
   bus_cfg_t          bus_cfg_q;
   logic [NUM_HS-1:0] hs_en_q;
   logic [NUM_LS-1:0] ls_en_q;
   logic [NUM_PWM-1:0] pwm_en_q;
   logic              sync_q;

   assign hs_load = wr_en && (wr_addr == A_HSPRE);
   assign ls_load = wr_en && (wr_addr == A_LSPRE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_cfg_q <= BUS_CFG_RST;
         hs_en_q   <= '0;
         ls_en_q   <= '0;
         pwm_en_q  <= '0;
         sync_q    <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            A_BUS:   bus_cfg_q <= bus_cfg_t'(wr_data[2:0]);
            A_HSEN:  hs_en_q   <= wr_data[NUM_HS-1:0];
            A_LSEN:  ls_en_q   <= wr_data[NUM_LS-1:0];
            A_PWMEN: pwm_en_q  <= wr_data[NUM_PWM-1:0];
            A_SYNC:  sync_q    <= wr_data[0];
            default: ;
         endcase
      end
   end

   pclk_prescaler #(.PRE_W(PRE_W), .RST_VAL(HS_RST)) u_hs_pre (
      .clk(clk), .rst_n(rst_n), .load(hs_load), .din(wr_data[PRE_W-1:0]), .tick(hs_tick));

   pclk_prescaler #(.PRE_W(PRE_W), .RST_VAL(LS_RST)) u_ls_pre (
      .clk(clk), .rst_n(rst_n), .load(ls_load), .din(wr_data[PRE_W-1:0]), .tick(ls_tick));

   pclk_busclk u_bus (
      .clk(clk), .rst_n(rst_n), .cfg(bus_cfg_q), .bus_tick(bus_stb), .out_tick(xout_stb));

   generate
      if (PWM_FROM_HS) begin : g_pwm_hs
         assign pwm_tick = hs_tick;
      end else begin : g_pwm_sys
         assign pwm_tick = 1'b1;
      end
   endgenerate

   pclk_gate #(.N(NUM_HS), .USE_HOLD(0)) u_hs_gate (
      .tick(hs_tick), .en(hs_en_q), .release_i(1'b1), .stb(hs_stb));

   pclk_gate #(.N(NUM_LS), .USE_HOLD(0)) u_ls_gate (
      .tick(ls_tick), .en(ls_en_q), .release_i(1'b1), .stb(ls_stb));

   pclk_gate #(.N(NUM_PWM), .USE_HOLD(1)) u_pwm_gate (
      .tick(pwm_tick), .en(pwm_en_q), .release_i(sync_q), .stb(pwm_stb));
endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk
   import pclk_pkg::*;
#(
   parameter int PRE_W   = 3,
   parameter int DATA_W  = 4,
   parameter int NUM_HS  = 4,
   parameter int NUM_LS  = 4,
   parameter int NUM_PWM = 4,
   parameter int HS_RST  = 1,
   parameter int LS_RST  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [2:0]         wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic               hs_tick,
   input logic               ls_tick,
   input logic [NUM_HS-1:0]  hs_stb,
   input logic [NUM_LS-1:0]  ls_stb,
   input logic [NUM_PWM-1:0] pwm_stb,
   input logic               bus_stb,
   input logic               xout_stb
);
   logic [PRE_W-1:0]   hs_pend, ls_pend;
   logic [7:0]         hs_gap, ls_gap, hs_exp, ls_exp;
   logic               hs_seen, ls_seen;
   logic [NUM_HS-1:0]  hs_en_m;
   logic [NUM_LS-1:0]  ls_en_m;
   logic [NUM_PWM-1:0] pwm_en_m;
   logic               sync_m, bus_half_m, clk_off_m;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_pend <= PRE_W'(HS_RST);  ls_pend <= PRE_W'(LS_RST);
         hs_gap <= '0; ls_gap <= '0; hs_exp <= '0; ls_exp <= '0;
         hs_seen <= 1'b0; ls_seen <= 1'b0;
         hs_en_m <= '0; ls_en_m <= '0; pwm_en_m <= '0;
         sync_m <= 1'b0; bus_half_m <= 1'b1; clk_off_m <= 1'b0;
      end else begin
         if (wr_en) begin
            case (wr_addr)
               A_HSPRE: hs_pend <= wr_data[PRE_W-1:0];
               A_LSPRE: ls_pend <= wr_data[PRE_W-1:0];
               A_BUS:   begin bus_half_m <= wr_data[0]; clk_off_m <= wr_data[2]; end
               A_HSEN:  hs_en_m  <= wr_data[NUM_HS-1:0];
               A_LSEN:  ls_en_m  <= wr_data[NUM_LS-1:0];
               A_PWMEN: pwm_en_m <= wr_data[NUM_PWM-1:0];
               A_SYNC:  sync_m   <= wr_data[0];
               default: ;
            endcase
         end
         if (hs_tick) begin
            hs_seen <= 1'b1; hs_gap <= '0; hs_exp <= 8'(pre_ratio(int'(hs_pend)));
         end else hs_gap <= hs_gap + 8'd1;
         if (ls_tick) begin
            ls_seen <= 1'b1; ls_gap <= '0; ls_exp <= 8'(pre_ratio(int'(ls_pend)));
         end else ls_gap <= ls_gap + 8'd1;
      end
   end

   // R2 and R4: fast tick spacing equals the ratio pending at the previous tick
   assert_hs_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_tick && hs_seen) |-> (hs_gap + 8'd1 == hs_exp));
   assert_ls_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_tick && ls_seen) |-> (ls_gap + 8'd1 == ls_exp));
   assert_gate_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_stb & ~hs_en_m) == '0);
   assert_gate_ls_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_stb & ~ls_en_m) == '0);
   assert_pwm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_m |-> (pwm_stb == '0));
   assert_pwm_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|pwm_stb) |-> (pwm_stb == pwm_en_m));
   assert_bus_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && bus_half_m) |=> !(bus_stb && bus_half_m));
   assert_bus_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_half_m |-> bus_stb);
   assert_xout_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xout_stb |-> (bus_stb && !clk_off_m));
endmodule

bind pclk_gen pclk_gen_chk #(
   .PRE_W(PRE_W), .DATA_W(DATA_W), .NUM_HS(NUM_HS), .NUM_LS(NUM_LS),
   .NUM_PWM(NUM_PWM), .HS_RST(HS_RST), .LS_RST(LS_RST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .hs_tick(hs_tick), .ls_tick(ls_tick), .hs_stb(hs_stb), .ls_stb(ls_stb),
   .pwm_stb(pwm_stb), .bus_stb(bus_stb), .xout_stb(xout_stb)
);

// File: tb/pclk_gen_tb.sv
module pclk_gen_tb;
   localparam int WIN = 840;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [3:0] wr_data = '0;
   logic [3:0] hs_stb, ls_stb, pwm_stb;
   logic       bus_stb, xout_stb;

   int nchk = 0, nerr = 0;
   int c_hs, c_ls, c_bus, c_out, c_pwm, c_bad;
   logic [3:0] m_hs_en, m_ls_en;

   always #10 clk = ~clk;

   pclk_gen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hs_stb(hs_stb), .ls_stb(ls_stb), .pwm_stb(pwm_stb),
      .bus_stb(bus_stb), .xout_stb(xout_stb));

   function automatic int exp_pre(input int n);
      return WIN / ((n == 0) ? 1 : 2 * n);
   endfunction
   function automatic int exp_bus(input logic [2:0] c);
      return c[0] ? WIN / 2 : WIN;
   endfunction
   function automatic int exp_out(input logic [2:0] c);
      return c[2] ? 0 : (exp_bus(c) / (c[1] ? 2 : 1));
   endfunction

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_now(input logic [2:0] a, input logic [3:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask
   task automatic wr(input logic [2:0] a, input logic [3:0] d);
      @(negedge clk);
      wr_now(a, d);
   endtask

   task automatic settle();
      repeat (32) @(negedge clk);
   endtask

   task automatic count_win();
      c_hs = 0; c_ls = 0; c_bus = 0; c_out = 0; c_pwm = 0; c_bad = 0;
      repeat (WIN) begin
         @(negedge clk);
         c_hs  += int'(hs_stb[0]);
         c_ls  += int'(ls_stb[0]);
         c_bus += int'(bus_stb);
         c_out += int'(xout_stb);
         c_pwm += int'(pwm_stb[0]);
         c_bad += int'(|(hs_stb & ~m_hs_en)) + int'(|(ls_stb & ~m_ls_en));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [2:0] hs_v, ls_v, bc;
      int g;
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: all gated strobes are off after reset
      check("R1 hs_stb", int'(hs_stb), 0);
      check("R1 ls_stb", int'(ls_stb), 0);
      check("R1 pwm_stb", int'(pwm_stb), 0);

      m_hs_en = 4'hF; m_ls_en = 4'hF;
      wr(3'd3, 4'hF);
      wr(3'd4, 4'hF);
      settle();
      count_win();
      check("R1 hs default rate", c_hs, exp_pre(1));
      check("R1 ls default rate", c_ls, exp_pre(2));
      check("R1 bus default rate", c_bus, exp_bus(3'b011));
      check("R1 xout default rate", c_out, exp_out(3'b011));

      // R2 / R3 directed extremes
      wr(3'd0, 4'd0);
      wr(3'd1, 4'd7);
      settle();
      count_win();
      check("R2 hs N=0", c_hs, exp_pre(0));
      check("R3 ls N=7", c_ls, exp_pre(7));

      // random settings for R2, R3, R5, R6
      for (int it = 0; it < 8; it++) begin
         hs_v = 3'($urandom % 8);
         ls_v = 3'($urandom % 8);
         bc   = 3'($urandom % 8);
         wr(3'd0, {1'b0, hs_v});
         wr(3'd1, {1'b0, ls_v});
         wr(3'd2, {1'b0, bc});
         settle();
         count_win();
         check("R2 hs random", c_hs, exp_pre(int'(hs_v)));
         check("R3 ls random", c_ls, exp_pre(int'(ls_v)));
         check("R5 bus random", c_bus, exp_bus(bc));
         check("R6 xout random", c_out, exp_out(bc));
      end
      wr(3'd2, 4'b0100);
      settle();
      count_win();
      check("R6 clock-off", c_out, 0);
      check("R5 bus full rate", c_bus, WIN);

      // R7 partial gating
      wr(3'd0, 4'd2);
      wr(3'd1, 4'd3);
      m_hs_en = 4'b0101; m_ls_en = 4'b0010;
      wr(3'd3, m_hs_en);
      wr(3'd4, m_ls_en);
      settle();
      count_win();
      check("R7 stray strobes", c_bad, 0);
      check("R7 hs bit0 on", c_hs, exp_pre(2));
      check("R7 ls bit0 off", c_ls, 0);

      // R9 unmapped write leaves everything unchanged
      wr(3'd7, 4'h0);
      settle();
      count_win();
      check("R9 hs unchanged", c_hs, exp_pre(2));
      check("R9 bus unchanged", c_bus, WIN);
      check("R9 stray strobes", c_bad, 0);

      // R8 hold and aligned release
      wr(3'd0, 4'd1);
      wr(3'd5, 4'hF);
      settle();
      count_win();
      check("R8 held while sync 0", c_pwm, 0);
      wr(3'd6, 4'h1);
      g = 0;
      while (pwm_stb == 4'h0 && g < 100) begin
         @(negedge clk);
         g++;
      end
      check("R8 aligned first strobe", int'(pwm_stb), 4'hF);
      count_win();
      check("R8 released rate", c_pwm, exp_pre(1));

      // R4 deferred prescale load
      m_hs_en = 4'hF;
      wr(3'd3, 4'hF);
      wr(3'd0, 4'd7);
      settle();
      g = 0;
      while (!hs_stb[0] && g < 100) begin
         @(negedge clk);
         g++;
      end
      wr_now(3'd0, 4'd1);
      g = 1;
      while (!hs_stb[0] && g < 100) begin
         @(negedge clk);
         g++;
      end
      check("R4 old period completes", g, 14);
      g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!hs_stb[0] && g < 100);
      check("R4 new period", g, 2);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule